// File: doc/BRIEF.md
# Masked Change-Detect Interrupt Controller

This block watches a set of already-synchronised input levels, arranged in banks of equal width, and raises an interrupt request when an enabled pin moves away from its reference level. The reference is the level captured the last time the input register of that pin's bank was read. A mask bit of 1 disables a pin and a mask bit of 0 enables it. The block takes the mask bits and the live levels from the neighbouring port register bank. That bank holds every mask bit at 1 after reset, so no interrupt can fire until software enables one.

Each detected change is held in a sticky per-pin pending bit. The surrounding logic pulses a per-bank strobe whenever software reads that bank's input register. The strobe clears the bank's pending bits and loads the current levels as the new reference. A status read returns one byte per bank, one cycle after the request, with masked pins forced to 0.

The request leaves the block as an output enable for an open-drain, active-low pad. A 1 pulls the line low; a 0 leaves it floating.

Top module: `icd_irq_ctrl`

## Requirements
- R1: A synchronous reset clears all pending bits, the request output and the status-valid flag, and loads the present pin levels as reference, so an unchanged pin raises nothing after reset.
- R2: When an unmasked pin differs from its reference at a clock edge, its pending bit is set at that edge and `irq_oe` reads 1 from the following edge on (one cycle of request latency).
- R3: A pin whose mask bit is 1 never raises the request, and its status bit always reads 0.
- R4: A pending bit is sticky: the pin returning to its reference level does not clear it.
- R5: A pulse on `in_rd_strobe[b]` clears every pending bit of bank b and loads bank b's present levels as its reference; other banks keep their pending bits.
- R6: `irq_oe` returns to 0 one edge after no unmasked pending bit remains, whether because of a clear strobe or because of masking.
- R7: Setting the mask bit of a pending pin hides that pin's status bit, and clearing the mask again shows it.
- R8: A status request with `stat_sel` = b returns bank b's masked status on `stat_data`, with `stat_vld` = 1 one cycle later. Bit i of that byte belongs to pin b*BANK_W+i.
- R9: A change in the same cycle as the bank's clear strobe goes into the new reference and raises no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | BANKS*BANK_W | Synchronised input levels |
| irq_mask | input | BANKS*BANK_W | Mask bits, 1 = disabled |
| in_rd_strobe | input | BANKS | Per-bank input-register read pulse |
| stat_req | input | 1 | Status read request |
| stat_sel | input | SELW | Bank selected for the status read |
| stat_data | output | BANK_W | Masked status byte |
| stat_vld | output | 1 | Status byte valid |
| irq_oe | output | 1 | Open-drain pull-down enable, 1 = line low |

## Verification
The bench uses the default two banks of eight pins. With two banks it can check that a clear strobe on one bank leaves the other bank's pending bits intact. It also drives the top pin of each bank, which confirms that the bits map to their bank byte without spilling into the neighbour. With eight-bit banks, each expected status byte reads as a direct per-pin pattern.

// File: rtl/icd_pkg.sv
package icd_pkg;
  typedef enum logic [0:0] {
    REQ_IDLE   = 1'b0,
    REQ_ACTIVE = 1'b1
  } irq_state_e;
endpackage

// File: rtl/icd_bank.sv
module icd_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_lvl,
  input  logic [W-1:0] mask,
  input  logic         rd_clr,
  output logic [W-1:0] stat_o,
  output logic         any_o
);
  logic [W-1:0] ref_q;
  logic [W-1:0] pend_q;
  logic [W-1:0] hit;

  assign hit = (pin_lvl ^ ref_q) & ~mask;

  always_ff @(posedge clk) begin
    if (rst || rd_clr) begin
      pend_q <= '0;
      ref_q  <= pin_lvl;
    end else begin
      pend_q <= pend_q | hit;
    end
  end

  assign stat_o = pend_q & ~mask;
  assign any_o  = |stat_o;

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    rd_clr |=> pend_q == '0); // R5
  AST_REF_RELOAD: assert property (@(posedge clk) disable iff (rst)
    rd_clr |=> ref_q == $past(pin_lvl)); // R5
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    !rd_clr |=> (pend_q & $past(pend_q)) == $past(pend_q)); // R4
endmodule

// File: rtl/icd_status_port.sv
module icd_status_port #(
  parameter int BANKS = 2,
  parameter int W     = 8,
  parameter int SELW  = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic [SELW-1:0]    sel,
  input  logic [BANKS*W-1:0] stat_flat,
  output logic [W-1:0]       data_o,
  output logic               vld_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= req;
      if (req) begin
        if (int'(sel) < BANKS) data_o <= stat_flat[int'(sel)*W +: W];
        else                   data_o <= '0;
      end
    end
  end
endmodule

// File: rtl/icd_irq_ctrl.sv
module icd_irq_ctrl #(
  parameter int BANKS  = 2,
  parameter int BANK_W = 8,
  parameter int SELW   = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [BANKS*BANK_W-1:0] pin_lvl,
  input  logic [BANKS*BANK_W-1:0] irq_mask,
  input  logic [BANKS-1:0]        in_rd_strobe,
  input  logic                    stat_req,
  input  logic [SELW-1:0]         stat_sel,
  output logic [BANK_W-1:0]       stat_data,
  output logic                    stat_vld,
  output logic                    irq_oe
);
  import icd_pkg::*;

  localparam int NPINS = BANKS * BANK_W;

  logic [NPINS-1:0] stat_flat;
  logic [BANKS-1:0] bank_any;
  irq_state_e       irq_q;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    icd_bank #(.W(BANK_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .pin_lvl (pin_lvl[b*BANK_W +: BANK_W]),
      .mask    (irq_mask[b*BANK_W +: BANK_W]),
      .rd_clr  (in_rd_strobe[b]),
      .stat_o  (stat_flat[b*BANK_W +: BANK_W]),
      .any_o   (bank_any[b])
    );
  end

  icd_status_port #(.BANKS(BANKS), .W(BANK_W), .SELW(SELW)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .req       (stat_req),
    .sel       (stat_sel),
    .stat_flat (stat_flat),
    .data_o    (stat_data),
    .vld_o     (stat_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= REQ_IDLE;
    else     irq_q <= (|bank_any) ? REQ_ACTIVE : REQ_IDLE;
  end

  assign irq_oe = (irq_q == REQ_ACTIVE);

  logic [BANK_W-1:0] sel_mask;
  always_comb begin
    sel_mask = '0;
    if (int'(stat_sel) < BANKS) sel_mask = irq_mask[int'(stat_sel)*BANK_W +: BANK_W];
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!irq_oe && !stat_vld)); // R1
  AST_MASKED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    stat_req |=> (stat_data & $past(sel_mask)) == '0); // R3
  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (&irq_mask) && $past(&irq_mask) && !$past(rst) |=> !irq_oe); // R3
endmodule

// File: tb/tb_icd_irq_ctrl.sv
module tb_icd_irq_ctrl;
  localparam int BANKS = 2;
  localparam int W     = 8;
  localparam int N     = BANKS * W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N-1:0]     pins = 16'hA5C3;
  logic [N-1:0]     mask = '1;
  logic [BANKS-1:0] strobe = '0;
  logic             stat_req = 1'b0;
  logic             stat_sel = 1'b0;
  logic [W-1:0]     stat_data;
  logic             stat_vld;
  logic             irq_oe;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [W-1:0] v;
    string        tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  icd_irq_ctrl #(.BANKS(BANKS), .BANK_W(W)) dut (
    .clk          (clk),
    .rst          (rst),
    .pin_lvl      (pins),
    .irq_mask     (mask),
    .in_rd_strobe (strobe),
    .stat_req     (stat_req),
    .stat_sel     (stat_sel),
    .stat_data    (stat_data),
    .stat_vld     (stat_vld),
    .irq_oe       (irq_oe)
  );

  // monitor: pops the scoreboard when a status byte appears
  always @(negedge clk) begin
    if (!rst && stat_vld) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R8: unexpected status byte %h, expected none", stat_data);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (stat_data !== it.v) begin
          errors++;
          $display("FAIL %s: status got %h expected %h", it.tag, stat_data, it.v);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_stat(input int bank, input logic [W-1:0] exp, input string tag);
    item_t it;
    it.v = exp;
    it.tag = tag;
    sb_q.push_back(it);
    stat_sel = bank[0];
    stat_req = 1'b1;
    cyc(1);
    stat_req = 1'b0;
    cyc(1);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (irq_oe !== exp) begin
      errors++;
      $display("FAIL %s: irq_oe got %b expected %b", tag, irq_oe, exp);
    end
  endtask

  task automatic pulse_strobe(input logic [BANKS-1:0] s);
    strobe = s;
    cyc(1);
    strobe = '0;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1: quiet after reset, reference equals current pins
    chk_irq(1'b0, "R1");
    checks++;
    if (stat_vld !== 1'b0) begin
      errors++;
      $display("FAIL R1: stat_vld got %b expected 0", stat_vld);
    end
    mask = '0;
    cyc(2);
    chk_irq(1'b0, "R1");
    read_stat(0, 8'h00, "R1");
    read_stat(1, 8'h00, "R1");

    // R3: all masked, changes ignored
    mask = '1;
    pins[0] = ~pins[0];
    pins[9] = ~pins[9];
    cyc(3);
    chk_irq(1'b0, "R3");
    read_stat(0, 8'h00, "R3");
    read_stat(1, 8'h00, "R3");

    // reload references, enable bank 0
    pulse_strobe(2'b11);
    mask = 16'hFF00;
    cyc(2);
    chk_irq(1'b0, "R5");

    // R2: change on pin 3, one cycle request latency
    pins[3] = ~pins[3];
    cyc(1);
    chk_irq(1'b0, "R2");
    cyc(1);
    chk_irq(1'b1, "R2");
    read_stat(0, 8'h08, "R2");
    read_stat(1, 8'h00, "R2");

    // R4: pin returns, bit stays
    pins[3] = ~pins[3];
    cyc(2);
    read_stat(0, 8'h08, "R4");
    chk_irq(1'b1, "R4");

    // R7 / R6: masking hides status and drops request
    mask[3] = 1'b1;
    cyc(1);
    chk_irq(1'b0, "R6");
    read_stat(0, 8'h00, "R7");
    mask[3] = 1'b0;
    cyc(1);
    chk_irq(1'b1, "R7");
    read_stat(0, 8'h08, "R7");

    // R5: bank 1 event, clear bank 0 only
    mask = '0;
    pins[12] = ~pins[12];
    cyc(2);
    pulse_strobe(2'b01);
    read_stat(0, 8'h00, "R5");
    read_stat(1, 8'h10, "R5");
    chk_irq(1'b1, "R5");
    strobe = 2'b10;
    cyc(1);
    strobe = '0;
    chk_irq(1'b1, "R6");
    cyc(1);
    chk_irq(1'b0, "R6");
    read_stat(1, 8'h00, "R5");

    // R9: change together with clear strobe
    pins[5] = ~pins[5];
    strobe = 2'b01;
    cyc(1);
    strobe = '0;
    cyc(2);
    chk_irq(1'b0, "R9");
    read_stat(0, 8'h00, "R9");

    // R8: top pin of each bank lands in its own byte
    pins[7]  = ~pins[7];
    pins[15] = ~pins[15];
    cyc(2);
    read_stat(0, 8'h80, "R8");
    read_stat(1, 8'h80, "R8");
    chk_irq(1'b1, "R8");

    // R1: reset while pending
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    cyc(1);
    chk_irq(1'b0, "R1");
    read_stat(0, 8'h00, "R1");
    read_stat(1, 8'h00, "R1");

    cyc(2);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R8: %0d status bytes missing, expected 0", sb_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule